// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides in which clock cycles the output-driver impedance code may be replaced by a freshly measured calibration value. A change of drive strength while the outputs are switching would disturb the data eye, so a new code is only taken in cycles where the outputs are idle: cycles that are not reads, or read cycles in which the output-enable pin holds the drivers off. Updates are also rate-limited. A free-running interval counter counts every clock cycle, whatever the operation, and an update is allowed only once that counter has reached its threshold.

The interval counter saturates at its threshold. During a long run of driving reads, a due update is therefore kept pending and is taken at the first idle cycle. A second counter tracks power-up settling. It counts cycles that are not reads, and once it reaches its limit it raises a settled flag, which stays high until the next reset. The analog measurement that produces the calibration code sits outside this block. The target drive impedance is one fifth of the external reference resistor.

Top module: `zq_update_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `appliedCode` equals the parameter RESET_CODE. `updStrobe` and `settled` are both 0.
- R2: Between two update edges there are at least GAP_CYCLES (default 32) full clock cycles, and the same holds between reset release and the first update. The interval counts every cycle, whatever the values of `readActive` and `outEnableN`.
- R3: An update is taken only at an edge where `readActive` is 0 or `outEnableN` is 1. A read with `outEnableN` at 0 never causes an update.
- R4: When an update is taken, `updStrobe` is 1 for exactly the following cycle. In that same cycle `appliedCode` shows the `calCode` value that was sampled at the update edge.
- R5: In any cycle where `updStrobe` is 0, `appliedCode` holds its previous value, whatever `calCode` does.
- R6: Once GAP_CYCLES cycles have passed since the last update (or since reset), the first edge that meets the R3 condition takes an update. A pending update is not lost, however long the preceding run of driving reads.
- R7: `settled` rises after SETTLE_CYCLES (default 1024) edges at which `readActive` was 0 have been counted since reset, whatever `outEnableN` is. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| readActive | input | 1 | High in a read cycle |
| outEnableN | input | 1 | Output-enable level; high keeps the drivers off |
| calCode | input | CODE_W | Latest measured calibration code |
| appliedCode | output | CODE_W | Impedance code currently driving the outputs |
| updStrobe | output | 1 | One-cycle pulse marking a new applied code |
| settled | output | 1 | Power-up settling complete |

## Verification
The hardest case to reach from the ports is a pending update that is held back by a long run of driving reads and then released. Mixed random traffic seldom produces it, because random traffic keeps hitting idle cycles. Directed phases therefore hold the block in reads with the outputs enabled well past the interval, then offer a single idle cycle and expect the update exactly there. A further phase of reads with the outputs disabled checks that such cycles still count as idle. Random traffic with a fixed seed then covers the spacing rule and the settling count against a reference model in the bench.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
  typedef struct packed {
    logic load;
  } zqStrobe_t;
endpackage

// File: rtl/zq_sched_ctrl.sv
module zq_sched_ctrl
  import zq_sched_pkg::*;
#(
  parameter int GAP_CYCLES    = 32,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      readActive,
  input  logic      outEnableN,
  output zqStrobe_t strobes,
  output logic      settled
);
  localparam int GAP_W    = $clog2(GAP_CYCLES + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  logic [GAP_W-1:0]    gapCnt;
  logic [SETTLE_W-1:0] settleCnt;
  logic                gapFull;
  logic                quietCycle;

  assign gapFull    = (gapCnt == GAP_W'(GAP_CYCLES));
  assign quietCycle = !readActive || outEnableN;
  assign strobes.load = gapFull && quietCycle;
  assign settled    = (settleCnt == SETTLE_W'(SETTLE_CYCLES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strobes.load) begin
      gapCnt <= '0;
    end else if (!gapFull) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settleCnt <= '0;
    end else if (!readActive && !settled) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  // pending update survives a driving read
  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gapFull && !quietCycle) |=> gapFull);

  // settled never drops once raised
  assert_settled_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);

  // settling only advances on non-read cycles
  assert_settle_nonread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    readActive |=> $stable(settleCnt));
endmodule

// File: rtl/zq_code_path.sv
module zq_code_path
  import zq_sched_pkg::*;
#(
  parameter int          CODE_W     = 6,
  parameter logic [5:0]  RESET_CODE = 6'd20,
  parameter int          GAP_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zqStrobe_t         strobes,
  input  logic [CODE_W-1:0] calCode,
  output logic [CODE_W-1:0] appliedCode,
  output logic              updStrobe
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      appliedCode <= CODE_W'(RESET_CODE);
      updStrobe   <= 1'b0;
    end else begin
      updStrobe <= strobes.load;
      if (strobes.load) appliedCode <= calCode;
    end
  end

  // spacing monitor: cycles since the last visible strobe
  logic [GAP_W-1:0] sinceUpd;
  always_ff @(posedge clk) begin
    if (!rst_n) sinceUpd <= '0;
    else if (updStrobe) sinceUpd <= GAP_W'(1);
    else if (sinceUpd != GAP_W'(GAP_CYCLES)) sinceUpd <= sinceUpd + 1'b1;
  end

  assert_update_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    updStrobe |-> (sinceUpd == GAP_W'(GAP_CYCLES)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    updStrobe |=> !updStrobe);

  assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !updStrobe |-> $stable(appliedCode));
endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched
  import zq_sched_pkg::*;
#(
  parameter int         CODE_W        = 6,
  parameter logic [5:0] RESET_CODE    = 6'd20,
  parameter int         GAP_CYCLES    = 32,
  parameter int         SETTLE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              readActive,
  input  logic              outEnableN,
  input  logic [CODE_W-1:0] calCode,
  output logic [CODE_W-1:0] appliedCode,
  output logic              updStrobe,
  output logic              settled
);
  zqStrobe_t strobes;

  zq_sched_ctrl #(
    .GAP_CYCLES(GAP_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .readActive(readActive),
    .outEnableN(outEnableN),
    .strobes(strobes),
    .settled(settled)
  );

  zq_code_path #(
    .CODE_W(CODE_W),
    .RESET_CODE(RESET_CODE),
    .GAP_CYCLES(GAP_CYCLES)
  ) i_path (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .calCode(calCode),
    .appliedCode(appliedCode),
    .updStrobe(updStrobe)
  );

  // a visible strobe follows an idle edge only
  assert_idle_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(updStrobe) |-> $past(!readActive || outEnableN));
endmodule

// File: tb/test_zq_update_sched.sv
module test_zq_update_sched;
  localparam int CW = 6;
  localparam int GAP = 32;
  localparam int SETTLE = 1024;
  localparam logic [5:0] RCODE = 6'd20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic readActive = 1'b0;
  logic outEnableN = 1'b0;
  logic [CW-1:0] calCode = '0;
  logic [CW-1:0] appliedCode;
  logic updStrobe;
  logic settled;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int strobeCount = 0;

  // reference model
  int mGap = 0;
  int mSettle = 0;
  logic [CW-1:0] mCode = RCODE;
  logic mStrobe = 1'b0;
  string mWhy = "R2";

  always #2 clk = ~clk;

  zq_update_sched #(.CODE_W(CW), .RESET_CODE(RCODE), .GAP_CYCLES(GAP),
                    .SETTLE_CYCLES(SETTLE)) i_zq_update_sched (
    .clk(clk), .rst_n(rst_n), .readActive(readActive), .outEnableN(outEnableN),
    .calCode(calCode), .appliedCode(appliedCode), .updStrobe(updStrobe),
    .settled(settled));

  function automatic logic isQuiet(logic ra, logic oen);
    return !ra || oen;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mGap = 0; mSettle = 0; mCode = RCODE; mStrobe = 1'b0; mWhy = "R1";
    end else begin
      mStrobe = (mGap == GAP) && isQuiet(readActive, outEnableN);
      if (mStrobe) begin
        mCode = calCode; mGap = 0; mWhy = "R6";
      end else begin
        mWhy = (mGap == GAP) ? "R3" : "R2";
        if (mGap < GAP) mGap++;
      end
      if (!readActive && mSettle < SETTLE) mSettle++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cmpAll();
    chk(mWhy, updStrobe, mStrobe);
    chk(mStrobe ? "R4" : "R5", appliedCode, mCode);
    chk("R7", settled, (mSettle == SETTLE) ? 1 : 0);
    if (updStrobe) strobeCount++;
  endtask

  // mode 0 random, 1 driving reads, 2 idle, 3 reads with outputs off
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmpAll();
      calCode = CW'($urandom);
      case (mode)
        0: begin readActive = 1'($urandom); outEnableN = (($urandom % 4) == 0); end
        1: begin readActive = 1'b1; outEnableN = 1'b0; end
        2: begin readActive = 1'b0; outEnableN = 1'($urandom); end
        default: begin readActive = 1'b1; outEnableN = 1'b1; end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", appliedCode, RCODE);
    chk("R1", updStrobe, 0);
    chk("R1", settled, 0);
    rst_n = 1'b1;
    // first update no earlier than the interval, then on the first idle edge
    run(40, 2);
    // long run of driving reads: nothing may be applied
    strobeCount = 0;
    run(80, 1);
    chk("R3", strobeCount, 0);
    // single idle cycle releases the pending update
    strobeCount = 0;
    run(3, 2);
    chk("R6", strobeCount, 1);
    // reads with outputs off count as idle
    strobeCount = 0;
    run(40, 3);
    chk("R3", strobeCount, 1);
    run(2600, 0);
    chk("R7", settled, 1);
    // reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", appliedCode, RCODE);
    chk("R1", settled, 0);
    rst_n = 1'b1;
    run(400, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule